// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This block evaluates relative jump instructions for a 16-bit processor pipeline. Each cycle in which `in_valid` is high, it receives one instruction word, the program counter already advanced by two past that word, and the status register. It finds out whether the word is a relative jump. If so, it tests the jump's condition against the carry, zero, negative and overflow flags, and it produces the address execution continues from.

The jump target is a signed 10-bit word displacement scaled to bytes and added to the advanced program counter. The addition wraps at 16 bits. Eight conditions are supported: tests on zero and carry, a negative test, two signed-compare tests built on the negative and overflow flags, and an unconditional jump. All results are registered and appear one cycle after the valid strobe. Instruction fetch, the register file and the other instruction classes belong to neighbouring blocks.

Top module: `br_eval_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `out_valid`, `is_jump`, `taken` and `next_pc` to zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. All results belong to the instruction presented at that edge.
- R3: A word is a jump when bits 15:13 equal 3'b001. Any other word gives `is_jump` = 0.
- R4: The condition code is bits 12:10. Code 0 takes the jump when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=1, 5 when N equals V, 6 when N differs from V, and 7 always.
- R5: A taken jump gives `next_pc` = `pc_inc` + 2 × (bits 9:0 sign-extended from bit 9), modulo 2^16.
- R6: A jump whose condition fails gives `taken` = 0 and `next_pc` = `pc_inc`.
- R7: A word that is not a jump gives `taken` = 0 and `next_pc` = `pc_inc`, whatever the flags.
- R8: The flags are read from `status` bit 0 (C), bit 1 (Z), bit 2 (N) and bit 8 (V). All other status bits have no effect.
- R9: A cycle with `in_valid` low gives, one cycle later, `out_valid` = 0, `is_jump` = 0 and `taken` = 0, and `next_pc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter already advanced past the word |
| status | input | 16 | Status register holding the C, Z, N and V flags |
| out_valid | output | 1 | Registered valid for the results |
| is_jump | output | 1 | The word was a relative jump |
| taken | output | 1 | The jump condition was met |
| next_pc | output | 16 | Address where execution continues |

## Verification
The cases that are hardest to reach from the ports are the two signed-compare conditions and the target wrapping across the 16-bit boundary in both directions. Each needs a specific pairing of flag bits and displacement. The stimulus table covers them on purpose: N and V set together, and each set alone; a forward step from 0xFFFE; a backward step from 0x0000; and both extremes of the displacement. Status words with every unused bit set show that only the four flag positions are read. Directed sequences then cover idle cycles, back-to-back valid cycles and a reset that arrives while results are held.

// File: rtl/br_eval_pkg.sv
package br_eval_pkg;

  typedef enum logic [2:0] {
    COND_Z_CLR  = 3'd0,
    COND_Z_SET  = 3'd1,
    COND_C_CLR  = 3'd2,
    COND_C_SET  = 3'd3,
    COND_N_SET  = 3'd4,
    COND_GE     = 3'd5,
    COND_LT     = 3'd6,
    COND_ALWAYS = 3'd7
  } cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  // Whether one condition code is met by a set of flags.
  function automatic logic cond_met(input cond_e code, input flags_t f);
    logic r;
    unique case (code)
      COND_Z_CLR:  r = ~f.z;
      COND_Z_SET:  r = f.z;
      COND_C_CLR:  r = ~f.c;
      COND_C_SET:  r = f.c;
      COND_N_SET:  r = f.n;
      COND_GE:     r = ~(f.n ^ f.v);
      COND_LT:     r = f.n ^ f.v;
      default:     r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode #(
  parameter int INSTR_W   = 16,
  parameter int CLASS_W   = 3,
  parameter logic [CLASS_W-1:0] CLASS_VAL = 3'b001,
  parameter int CC_W      = 3,
  parameter int OFF_W     = 10
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               is_jump,
  output br_eval_pkg::cond_e cc,
  output logic [OFF_W-1:0]   off
);
  localparam int CLASS_LSB = INSTR_W - CLASS_W;
  localparam int CC_LSB    = OFF_W;

  // Jump class sits in the top bits (R3)
  assign is_jump = (instr[CLASS_LSB +: CLASS_W] == CLASS_VAL);
  // Condition code just above the displacement (R4)
  assign cc      = br_eval_pkg::cond_e'(instr[CC_LSB +: CC_W]);
  assign off     = instr[OFF_W-1:0];
endmodule

// File: rtl/br_flag_pick.sv
module br_flag_pick #(
  parameter int STAT_W = 16,
  parameter int C_POS  = 0,
  parameter int Z_POS  = 1,
  parameter int N_POS  = 2,
  parameter int V_POS  = 8
) (
  input  logic [STAT_W-1:0]   status,
  output br_eval_pkg::flags_t flags
);
  // Only these four positions are read (R8)
  assign flags.c = status[C_POS];
  assign flags.z = status[Z_POS];
  assign flags.n = status[N_POS];
  assign flags.v = status[V_POS];
endmodule

// File: rtl/br_cond.sv
module br_cond #(
  parameter int CC_W = 3
) (
  input  logic                is_jump,
  input  br_eval_pkg::cond_e  cc,
  input  br_eval_pkg::flags_t flags,
  output logic                take
);
  import br_eval_pkg::*;
  localparam int NUM_COND = 1 << CC_W;

  logic [NUM_COND-1:0] hit;

  for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
    localparam logic [CC_W-1:0] CODE = CC_W'(g);
    assign hit[g] = cond_met(cond_e'(CODE), flags);
  end

  assign take = is_jump & hit[cc];

  // Exactly one of the signed-compare tests holds for any flags
  always_comb begin
    AST_SIGNED_PAIR: assert (hit[COND_GE] != hit[COND_LT]); // R4
    AST_ZERO_PAIR: assert (hit[COND_Z_CLR] != hit[COND_Z_SET]); // R4
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 10
) (
  input  logic [PC_W-1:0]  pc_inc,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - OFF_W;

  // Word displacement to a byte step, sign-extended to PC width
  function automatic logic [PC_W-1:0] byte_step(input logic [OFF_W-1:0] o);
    logic [PC_W-1:0] ext;
    ext = {{EXT_W{o[OFF_W-1]}}, o};
    return ext << 1;
  endfunction

  // Addition wraps at PC width (R5)
  assign target = pc_inc + byte_step(off);
endmodule

// File: rtl/br_eval_unit.sv
module br_eval_unit #(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 10,
  parameter int CC_W   = 3,
  parameter int CLASS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [PC_W-1:0] instr,
  input  logic [PC_W-1:0] pc_inc,
  input  logic [PC_W-1:0] status,
  output logic            out_valid,
  output logic            is_jump,
  output logic            taken,
  output logic [PC_W-1:0] next_pc
);
  import br_eval_pkg::*;

  logic             dec_jump;
  cond_e            dec_cc;
  logic [OFF_W-1:0] dec_off;
  flags_t           cur_flags;
  logic             take_now;
  logic [PC_W-1:0]  jump_target;
  logic [PC_W-1:0]  pc_choice;

  br_decode #(
    .INSTR_W(PC_W), .CLASS_W(CLASS_W), .CLASS_VAL(CLASS_W'(1)),
    .CC_W(CC_W), .OFF_W(OFF_W)
  ) decode_i (
    .instr(instr), .is_jump(dec_jump), .cc(dec_cc), .off(dec_off)
  );

  br_flag_pick #(.STAT_W(PC_W)) flags_i (
    .status(status), .flags(cur_flags)
  );

  br_cond #(.CC_W(CC_W)) cond_i (
    .is_jump(dec_jump), .cc(dec_cc), .flags(cur_flags), .take(take_now)
  );

  br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) target_i (
    .pc_inc(pc_inc), .off(dec_off), .target(jump_target)
  );

  // Untaken or non-jump words continue in sequence (R6, R7)
  assign pc_choice = take_now ? jump_target : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      is_jump   <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_jump <= dec_jump;
        taken   <= take_now;
        next_pc <= pc_choice;
      end else begin
        is_jump <= 1'b0;
        taken   <= 1'b0;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_TAKEN_IS_JUMP: assert property (@(posedge clk) disable iff (rst)
    taken |-> (is_jump && out_valid)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!is_jump && !taken && !out_valid)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> $stable(next_pc)); // R9
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !take_now) |=> (next_pc == $past(pc_inc))); // R6
  AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_jump && dec_cc == COND_ALWAYS) |=> taken); // R4
  AST_EVEN_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && take_now) |=> (next_pc[0] == $past(pc_inc[0]))); // R5
endmodule

// File: tb/br_eval_unit_tb_top.sv
module br_eval_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, status = '0;
  logic        out_valid, is_jump, taken;
  logic [15:0] next_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_eval_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .pc_inc(pc_inc), .status(status), .out_valid(out_valid),
    .is_jump(is_jump), .taken(taken), .next_pc(next_pc)
  );

  // {instr, pc_inc, status, exp_jump, exp_taken, exp_next_pc}
  localparam logic [65:0] VEC [NVEC] = '{
    {16'h2005, 16'h1000, 16'h0000, 1'b1, 1'b1, 16'h100A}, // R4 Z clear taken
    {16'h2005, 16'h1000, 16'h0002, 1'b1, 1'b0, 16'h1000}, // R6 Z clear fails
    {16'h2405, 16'h2000, 16'h0002, 1'b1, 1'b1, 16'h200A}, // R4 Z set
    {16'h2405, 16'h2000, 16'h0000, 1'b1, 1'b0, 16'h2000}, // R6
    {16'h2BFF, 16'h3000, 16'h0000, 1'b1, 1'b1, 16'h2FFE}, // R5 offset -1
    {16'h2BFF, 16'h3000, 16'h0001, 1'b1, 1'b0, 16'h3000}, // R6 C set
    {16'h2E00, 16'h4000, 16'h0001, 1'b1, 1'b1, 16'h3C00}, // R5 offset -512
    {16'h31FF, 16'h0100, 16'h0004, 1'b1, 1'b1, 16'h04FE}, // R5 offset +511
    {16'h31FF, 16'h0100, 16'h0000, 1'b1, 1'b0, 16'h0100}, // R6 N clear
    {16'h3410, 16'h0500, 16'h0104, 1'b1, 1'b1, 16'h0520}, // R4 GE N=V=1
    {16'h3410, 16'h0500, 16'h0000, 1'b1, 1'b1, 16'h0520}, // R4 GE N=V=0
    {16'h3410, 16'h0500, 16'h0004, 1'b1, 1'b0, 16'h0500}, // R4 GE fails
    {16'h3810, 16'h0600, 16'h0100, 1'b1, 1'b1, 16'h0620}, // R4 LT V only
    {16'h3810, 16'h0600, 16'h0000, 1'b1, 1'b0, 16'h0600}, // R4 LT fails
    {16'h3C01, 16'hFFFE, 16'hFFFF, 1'b1, 1'b1, 16'h0000}, // R5 wrap up
    {16'h3FFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'hFFFE}, // R5 wrap down
    {16'h4130, 16'h1234, 16'h0000, 1'b0, 1'b0, 16'h1234}, // R3 class 010
    {16'hE3FF, 16'h5678, 16'hFFFF, 1'b0, 1'b0, 16'h5678}, // R7 class 111
    {16'h2005, 16'h1000, 16'hFFFD, 1'b1, 1'b1, 16'h100A}, // R8 spare bits set
    {16'h3810, 16'h0600, 16'hFEF8, 1'b1, 1'b0, 16'h0600}, // R8 spare bits set
    {16'h2405, 16'h2000, 16'hFEFD, 1'b1, 1'b0, 16'h2000}  // R8 Z clear
  };

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%0b j=%0b t=%0b pc=%h, expected v=%0b j=%0b t=%0b pc=%h",
               req, act[18], act[17], act[16], act[15:0],
               exp[18], exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic present(input logic [15:0] i, input logic [15:0] p, input logic [15:0] s);
    instr = i; pc_inc = p; status = s; in_valid = 1'b1;
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {out_valid, is_jump, taken, next_pc}, 19'h0);
    rst = 1'b0;

    // Stimulus table: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      present(VEC[k][65:50], VEC[k][49:34], VEC[k][33:18]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R4/R5 vector %0d", k), {out_valid, is_jump, taken, next_pc},
            {1'b1, VEC[k][17:0]});
    end

    // R9: idle after a taken jump keeps next_pc, clears flags
    @(negedge clk);
    present(16'h3C04, 16'h0800, 16'h0000);
    @(negedge clk);
    in_valid = 1'b0;
    held = next_pc;
    check("R5 setup", {out_valid, is_jump, taken, next_pc}, {3'b111, 16'h0808});
    instr = 16'h2005; pc_inc = 16'hAAAA;
    @(negedge clk);
    check("R9 idle", {out_valid, is_jump, taken, next_pc}, {3'b000, held});
    @(negedge clk);
    check("R9 idle second cycle", {out_valid, is_jump, taken, next_pc}, {3'b000, held});

    // R2: back-to-back valid cycles, each result one cycle later
    present(16'h2005, 16'h1000, 16'h0000);
    @(negedge clk);
    check("R2 first", {out_valid, is_jump, taken, next_pc}, {3'b111, 16'h100A});
    present(16'h4130, 16'h2222, 16'h0000);
    @(negedge clk);
    check("R2 second", {out_valid, is_jump, taken, next_pc}, {3'b100, 16'h2222});
    present(16'h2805, 16'h3000, 16'h0001);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 third", {out_valid, is_jump, taken, next_pc}, {3'b110, 16'h3000});

    // R1: reset while results are held
    present(16'h3C10, 16'h7000, 16'h0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", {out_valid, is_jump, taken, next_pc}, 19'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 after reset", {out_valid, is_jump, taken, next_pc}, 19'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule